// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block controls one successive-approximation conversion from start to finish. A start pulse from a bus decoder begins a conversion. A short-cycle flag, sampled with that pulse, chooses how many bits are resolved. The block drives the trial code to an external DAC and reads back a comparator. The comparator is high when the trial code lies above the held input. The block also drives the hold/sample control of the track-and-hold, a busy line, a data-ready flag and the final result word.

A conversion runs in four steps:
1. The block enters hold and waits a settling interval.
2. It tests the bits one at a time, starting at the most significant bit.
3. It returns the track-and-hold to sample mode and publishes the result.
4. It keeps busy high for an acquisition interval, so the next sample is clean.

The result can be read during that acquisition interval. All intervals are parameters counted in clock cycles. At 50 MHz the defaults give a full conversion of 340 cycles (6.8 µs).

Top module: `sar_sequencer`

## Requirements
- R1: After a synchronous reset the block is idle. busy, hold and data_ready are 0, and result and dac_code are 0.
- R2: A start seen while idle sets busy and hold at the next edge. dac_code then stays 0 for SETTLE_CYC cycles, which is the hold-settling interval.
- R3: The bits are tried from bit NBITS-1 downward, each for BIT_CYC cycles. During the trial of bit k, dac_code holds the bits already decided above k, with bit k set and all lower bits 0. At the end of the trial, bit k is cleared if cmp_above is 1 and kept if it is 0.
- R4: With short_cyc low at start, all NBITS bits are tried. For a comparator that reports (dac_code > target), the result equals target.
- R5: With short_cyc high at start, only the top SHORT_BITS bits are tried. The low NBITS-SHORT_BITS result bits are 0, and busy lasts (NBITS-SHORT_BITS)*BIT_CYC cycles less than in a full conversion.
- R6: While busy, start pulses and changes of short_cyc have no effect. The conversion is neither restarted nor shortened.
- R7: When the last trial ends, hold falls. busy stays high for exactly ACQ_CYC more cycles and then falls.
- R8: result and data_ready are updated in the same cycle that hold falls, so data is readable ACQ_CYC cycles before busy falls. result changes at no other time. data_ready clears when the next conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Convert command, sampled when idle |
| short_cyc | input | 1 | 1 = resolve only the top SHORT_BITS bits; sampled with start |
| cmp_above | input | 1 | Comparator: 1 when the trial code lies above the held input |
| dac_code | output | NBITS | Trial code driven to the DAC |
| hold | output | 1 | 1 = track-and-hold in hold mode |
| busy | output | 1 | Conversion in progress, including acquisition |
| data_ready | output | 1 | result holds a finished conversion |
| result | output | NBITS | Last finished conversion |

## Verification
The bench's comparator model compares dac_code against a target code. The stimulus covers several target shapes:
- All ones and all zeros, which keep every trial bit or drop every trial bit.
- Values on either side of mid-scale (0x800 and 0x7FF), which separate the decision on the top bit from the decisions below it.
- Mixed patterns, which expose bit-order or bit-index errors.

Short conversions use targets with nonzero low bits, to show that those bits are truncated rather than converted. A further run sends start pulses and toggles short_cyc during settling, trials and acquisition. Back-to-back conversions show that data_ready clears on the new start while the old result stays in place.

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int NBITS      = 12,
  parameter int SHORT_BITS = 8,
  parameter int SETTLE_CYC = 50,
  parameter int BIT_CYC    = 20,
  parameter int ACQ_CYC    = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             short_cyc,
  input  logic             cmp_above,
  output logic [NBITS-1:0] dac_code,
  output logic             hold,
  output logic             busy,
  output logic             data_ready,
  output logic [NBITS-1:0] result
);
  localparam int IW   = $clog2(NBITS);
  localparam int CMAX = (SETTLE_CYC > BIT_CYC) ? ((SETTLE_CYC > ACQ_CYC) ? SETTLE_CYC : ACQ_CYC)
                                               : ((BIT_CYC > ACQ_CYC) ? BIT_CYC : ACQ_CYC);
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [IW-1:0] TOP_IDX    = IW'(NBITS - 1);
  localparam logic [IW-1:0] SHORT_LAST = IW'(NBITS - SHORT_BITS);

  typedef enum logic [1:0] {IDLE, SETTLE, TRIAL, ACQUIRE} state_t;

  state_t           state;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    idx;
  logic             short_q;
  logic [NBITS-1:0] sar, decided;

  wire cnt_done = (cnt == '0);
  wire last_bit = (idx == (short_q ? SHORT_LAST : '0));

  always_comb begin
    decided = sar;
    if (cmp_above) decided[idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= IDLE;
      cnt        <= '0;
      idx        <= '0;
      short_q    <= 1'b0;
      sar        <= '0;
      result     <= '0;
      data_ready <= 1'b0;
    end else begin
      case (state)
        IDLE: if (start) begin
          state      <= SETTLE;
          cnt        <= CW'(SETTLE_CYC - 1);
          sar        <= '0;
          short_q    <= short_cyc;
          data_ready <= 1'b0;
        end
        SETTLE: if (cnt_done) begin
          state        <= TRIAL;
          idx          <= TOP_IDX;
          sar[TOP_IDX] <= 1'b1;
          cnt          <= CW'(BIT_CYC - 1);
        end else cnt <= cnt - 1'b1;
        TRIAL: if (cnt_done) begin
          sar <= decided;
          if (last_bit) begin
            state      <= ACQUIRE;
            cnt        <= CW'(ACQ_CYC - 1);
            result     <= decided;
            data_ready <= 1'b1;
          end else begin
            idx                 <= idx - 1'b1;
            sar[idx - 1'b1]     <= 1'b1;
            cnt                 <= CW'(BIT_CYC - 1);
          end
        end else cnt <= cnt - 1'b1;
        ACQUIRE: if (cnt_done) state <= IDLE;
                 else cnt <= cnt - 1'b1;
        default: state <= IDLE;
      endcase
    end
  end

  assign dac_code = sar;
  assign hold     = (state == SETTLE) || (state == TRIAL);
  assign busy     = (state != IDLE);

  // R2: a conversion begins in hold with an empty trial code
  p_enter_hold_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (hold && dac_code == '0));

  // R7: hold is only ever a sub-interval of busy
  p_hold_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
    hold |-> busy);

  // R8: busy can only fall with data already published
  p_ready_before_idle_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> data_ready);

  // R8: result moves only at the end of the trials
  p_result_only_at_end_r8: assert property (@(posedge clk) disable iff (rst)
    !$fell(hold) |-> $stable(result));

  // R6: a start during the trials does not send the block back to settling
  p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (state == TRIAL && start) |=> (state != SETTLE));

  // R5: a short conversion leaves the low bits clear
  p_short_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (data_ready && short_q) |-> (result[NBITS-SHORT_BITS-1:0] == '0));
endmodule

// File: tb/sar_sequencer_test.sv
module sar_sequencer_test;
  localparam int N = 12, SB = 8, S = 50, B = 20, A = 50;

  logic clk = 1'b0;
  logic rst = 1'b1, start = 1'b0, short_cyc = 1'b0;
  logic [N-1:0] dac_code, result;
  logic hold, busy, data_ready, cmp_above;
  int target = 0;

  always #10 clk = ~clk;

  assign cmp_above = (int'(dac_code) > target);

  sar_sequencer #(.NBITS(N), .SHORT_BITS(SB), .SETTLE_CYC(S), .BIT_CYC(B), .ACQ_CYC(A)) uut (
    .clk(clk), .rst(rst), .start(start), .short_cyc(short_cyc), .cmp_above(cmp_above),
    .dac_code(dac_code), .hold(hold), .busy(busy), .data_ready(data_ready), .result(result));

  int vectors = 0, errors = 0;
  int t = 0, nb = N, mtgt = 0, e_res = 0;
  bit e_rdy = 0;

  function automatic int topmask(int k);
    return ((1 << k) - 1) << (N - k);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: t counts cycles since an accepted start
  always @(posedge clk) begin
    if (rst) begin
      t = 0; e_res = 0; e_rdy = 0;
    end else if (t == 0) begin
      if (start) begin
        t = 1; nb = short_cyc ? SB : N; mtgt = target; e_rdy = 0;
      end
    end else begin
      t = (t == S + nb*B + A) ? 0 : t + 1;
      if (t == S + nb*B + 1) begin
        e_res = mtgt & topmask(nb); e_rdy = 1;
      end
    end
  end

  always @(negedge clk) if (!rst) begin
    int tend, k, e_dac;
    tend = S + nb*B;
    chk(busy == (t != 0), (t > tend) ? "R7 busy" : "R2 busy", busy, t != 0);
    chk(hold == (t >= 1 && t <= tend), (t > tend) ? "R7 hold" : "R2 hold", hold, t >= 1 && t <= tend);
    chk(data_ready == e_rdy, "R8 ready", data_ready, e_rdy);
    chk(result == N'(e_res), (nb == SB) ? "R5 result" : "R4 result", result, e_res);
    if (t >= 1 && t <= S) chk(dac_code == '0, "R2 settle code", dac_code, 0);
    else if (t > S && t <= tend) begin
      k = (t - S - 1) / B;
      e_dac = (mtgt & topmask(k)) | (1 << (N - 1 - k));
      chk(dac_code == N'(e_dac), "R3 trial code", dac_code, e_dac);
    end
  end

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  task automatic convert(int tgt, bit sh, bit poke);
    @(negedge clk);
    target = tgt; short_cyc = sh; start = 1'b1;
    @(negedge clk);
    start = 1'b0; short_cyc = 1'b0;
    while (t != 0) begin
      @(negedge clk);
      if (poke) begin  // R6: stray commands mid-conversion
        start = ($urandom_range(3) == 0);
        short_cyc = ~short_cyc;
      end
    end
    start = 1'b0; short_cyc = 1'b0;
    if (sh) chk(result == N'(tgt & topmask(SB)), "R5 final", result, tgt & topmask(SB));
    else    chk(result == N'(tgt), "R4 final", result, tgt);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int c;
    c = 0;
    forever begin
      @(posedge clk);
      c++;
      if (c > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", c);
        finish_up();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !hold && !data_ready && result == '0 && dac_code == '0, "R1 reset",
        {busy, hold, data_ready}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && result == '0, "R1 idle after reset", busy, 0);
    convert(12'hFFF, 1'b0, 1'b0);
    convert(12'h000, 1'b0, 1'b0);
    convert(12'h800, 1'b0, 1'b0);
    convert(12'h7FF, 1'b0, 1'b0);
    convert(12'hA5C, 1'b0, 1'b0);
    convert(12'hABC, 1'b1, 1'b0);
    convert(12'h00F, 1'b1, 1'b0);
    convert(12'h3C7, 1'b0, 1'b1);
    convert(12'hE19, 1'b1, 1'b1);
    // back-to-back: start held high, ready must drop on restart (R8)
    @(negedge clk);
    target = 12'h5A5; start = 1'b1;
    while (t == 0 || t < S + N*B + A) @(negedge clk);
    target = 12'h1E3;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy && !data_ready && result == 12'h5A5, "R8 restart keeps old result",
        result, 12'h5A5);
    while (t != 0) @(negedge clk);
    chk(result == 12'h1E3, "R4 back-to-back", result, 12'h1E3);
    finish_up();
  end
endmodule